// File: doc/BRIEF.md
# External Oscillator Failure Detector

This block watches a crystal-driven external clock from a separate, always-running reference clock and reports a failure when the external clock stops or slows too far. Software must set an enable bit before any checking happens. The detector then waits until the oscillator is switched on and reports itself stable through its ready signal. Only at that point does it start judging the external clock. Switching the oscillator off drops the detector back to its idle state.

The external clock passes through a synchronizer into the reference domain, and its rising edges are counted over a fixed window of reference cycles. A window that closes with too few edges is a failure. On a failure the block does four things. It drives a force-off request to the oscillator, which stays asserted until the oscillator enable actually falls. It emits a one-cycle break pulse for a timer. It raises a sticky interrupt flag that software clears with a write-one strobe. If the external clock was feeding the system clock, either directly or through the PLL, it also raises a request for the clock switch to fall back to the internal RC oscillator.

The control path is a four-state machine. DISARMED is the idle and reset state. ARMED counts windows. TRIP lasts one cycle and carries the break pulse. HALTED holds the oscillator off. The transitions are:
- DISARMED to ARMED when enable, oscillator-on and ready are all high.
- ARMED to DISARMED when enable or oscillator-on falls; this takes priority.
- ARMED to TRIP when a window closes short.
- TRIP to HALTED unconditionally.
- HALTED to DISARMED when oscillator-on falls.

Top module: `xosc_fail_monitor`

## Requirements
- R1: After reset, fail_irq, brk_pulse, xosc_force_off and fallback_req are all low and the machine is DISARMED.
- R2: While mon_en is low, no failure is ever reported, even with the external clock stopped.
- R3: With xosc_on high but xosc_ready low, the detector stays unarmed and reports no failure.
- R4: Dropping xosc_on while armed disarms the detector; no failure is reported for the unfinished window.
- R5: A window of WIN_CYCLES (16) reference cycles that sees fewer than MIN_EDGES (2) synchronized rising edges of xosc_clk is a failure. Two or more edges in every window is not.
- R6: With the external clock stopped, the failure outputs appear after the 16th reference edge following the edge that arms the detector, and not after the 15th.
- R7: xosc_force_off rises together with the failure and stays high until xosc_on is seen low, after which it is low one cycle later.
- R8: brk_pulse is high for exactly one reference cycle per failure.
- R9: fail_irq is set on a failure and stays set until a cycle with irq_clr high. If a failure and irq_clr coincide, the flag stays set.
- R10: fallback_req is set on a failure only when sys_src is 01 (external direct) or 10 (PLL) with pll_src_ext high. It is not set for 00 (internal RC), nor for 10 with pll_src_ext low. It is cleared by irq_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that runs the detector |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Software enable for monitoring |
| xosc_on | input | 1 | External oscillator switched on |
| xosc_ready | input | 1 | External oscillator startup delay elapsed |
| xosc_clk | input | 1 | External oscillator clock being watched |
| sys_src | input | 2 | System clock source: 00 RC, 01 external, 10 PLL |
| pll_src_ext | input | 1 | PLL input taken from the external oscillator |
| irq_clr | input | 1 | Write-one strobe clearing fail_irq and fallback_req |
| fail_irq | output | 1 | Sticky failure interrupt flag |
| brk_pulse | output | 1 | One-cycle break event for a timer |
| xosc_force_off | output | 1 | Request forcing the external oscillator off |
| fallback_req | output | 1 | Request to switch the system clock to the internal RC |

## Verification
All four failure outputs change after the same reference edge: the edge on which a short window closes, 16 edges after the arming edge. brk_pulse drops again after the following edge, and xosc_force_off falls one edge after xosc_on is seen low. The bench drives its inputs and samples its outputs on the falling edge of the reference clock, so each check lands on a known cycle count. The exact-cycle check of R6 uses a stopped external clock, because its result does not depend on window alignment. The table-driven rate checks wait several whole windows before reading the flag, so that edge phase cannot change the outcome.

// File: rtl/xfd_pkg.sv
package xfd_pkg;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_TRIP     = 2'd2,
        ST_HALTED   = 2'd3
    } xfd_state_e;

    typedef enum logic [1:0] {
        SRC_RC   = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_PLL  = 2'b10,
        SRC_RSVD = 2'b11
    } sys_src_e;

endpackage

// File: rtl/xfd_edge_sync.sv
module xfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/xfd_window.sv
module xfd_window #(
    parameter int WIN_CYCLES = 16,
    parameter int MIN_EDGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic edge_seen,
    output logic win_short
);
    localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);
    localparam logic [EW-1:0] SAT  = EW'(MIN_EDGES);

    logic [CW-1:0] cyc_q;
    logic [EW-1:0] edges_q;
    logic [EW:0]   tally;
    logic          at_end;

    assign at_end = run && (cyc_q == LAST);

    always_comb begin
        tally     = {1'b0, edges_q} + {{EW{1'b0}}, edge_seen};
        win_short = at_end && (tally < (EW+1)'(MIN_EDGES));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            edges_q <= '0;
        end else if (!run || at_end) begin
            cyc_q   <= '0;
            edges_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (edge_seen && edges_q != SAT) edges_q <= edges_q + 1'b1;
        end
    end
endmodule

// File: rtl/xosc_fail_monitor.sv
module xosc_fail_monitor
    import xfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYCLES  = 16,
    parameter int MIN_EDGES   = 2
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       mon_en,
    input  logic       xosc_on,
    input  logic       xosc_ready,
    input  logic       xosc_clk,
    input  logic [1:0] sys_src,
    input  logic       pll_src_ext,
    input  logic       irq_clr,
    output logic       fail_irq,
    output logic       brk_pulse,
    output logic       xosc_force_off,
    output logic       fallback_req
);
    xfd_state_e state_q, state_d;
    logic       ext_rise;
    logic       win_short;
    logic       arm_ok;
    logic       keep_armed;
    logic       ext_feeds_sys;
    logic       trip_now;
    logic       irq_q, fb_q;

    xfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .async_in (xosc_clk),
        .rise     (ext_rise)
    );

    xfd_window #(.WIN_CYCLES(WIN_CYCLES), .MIN_EDGES(MIN_EDGES)) u_win (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_ARMED),
        .edge_seen (ext_rise),
        .win_short (win_short)
    );

    assign arm_ok        = mon_en && xosc_on && xosc_ready;
    assign keep_armed    = mon_en && xosc_on;
    assign ext_feeds_sys = (sys_src == SRC_EXT) || ((sys_src == SRC_PLL) && pll_src_ext);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (arm_ok) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!keep_armed)    state_d = ST_DISARMED;
                else if (win_short) state_d = ST_TRIP;
            end
            ST_TRIP:   state_d = ST_HALTED;
            ST_HALTED: if (!xosc_on) state_d = ST_DISARMED;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    assign trip_now = (state_q == ST_ARMED) && (state_d == ST_TRIP);

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fb_q  <= 1'b0;
        end else begin
            if (trip_now)     irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
            if (trip_now && ext_feeds_sys) fb_q <= 1'b1;
            else if (irq_clr)              fb_q <= 1'b0;
        end
    end

    always_comb begin
        brk_pulse      = 1'b0;
        xosc_force_off = 1'b0;
        unique case (state_q)
            ST_DISARMED, ST_ARMED: ;
            ST_TRIP: begin
                brk_pulse      = 1'b1;
                xosc_force_off = 1'b1;
            end
            ST_HALTED: xosc_force_off = 1'b1;
        endcase
    end

    assign fail_irq     = irq_q;
    assign fallback_req = fb_q;
endmodule

// File: rtl/xosc_fail_monitor_chk.sv
module xosc_fail_monitor_chk (
    input logic ref_clk,
    input logic rst_n,
    input logic mon_en,
    input logic xosc_on,
    input logic irq_clr,
    input logic fail_irq,
    input logic brk_pulse,
    input logic xosc_force_off,
    input logic fallback_req
);
    assert_no_break_disabled_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !mon_en |=> !brk_pulse);

    assert_no_break_when_off_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !xosc_on |=> !brk_pulse);

    assert_force_with_break_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        brk_pulse |-> xosc_force_off);

    assert_force_held_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (xosc_force_off && xosc_on) |=> xosc_force_off);

    assert_break_single_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);

    assert_irq_with_break_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        brk_pulse |-> fail_irq);

    assert_irq_sticky_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (fail_irq && !irq_clr) |=> fail_irq);

    assert_irq_rise_cause_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(fail_irq) |-> brk_pulse);

    assert_fallback_cause_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(fallback_req) |-> brk_pulse);
endmodule

bind xosc_fail_monitor xosc_fail_monitor_chk u_chk (
    .ref_clk        (ref_clk),
    .rst_n          (rst_n),
    .mon_en         (mon_en),
    .xosc_on        (xosc_on),
    .irq_clr        (irq_clr),
    .fail_irq       (fail_irq),
    .brk_pulse      (brk_pulse),
    .xosc_force_off (xosc_force_off),
    .fallback_req   (fallback_req)
);

// File: tb/xosc_fail_monitor_tb.sv
module xosc_fail_monitor_tb_top;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_en = 1'b0;
    logic       xosc_on = 1'b0;
    logic       xosc_ready = 1'b0;
    logic       xosc_clk = 1'b0;
    logic [1:0] sys_src = 2'b00;
    logic       pll_src_ext = 1'b0;
    logic       irq_clr = 1'b0;
    logic       fail_irq, brk_pulse, xosc_force_off, fallback_req;

    int checks = 0;
    int errors = 0;
    int half_per = 0;
    int ext_cnt = 0;
    bit done = 1'b0;

    localparam int NVEC = 6;
    localparam int HALF_TAB [NVEC] = '{1, 2, 3, 4, 8, 0};
    localparam bit FAIL_TAB [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    always #2 ref_clk = ~ref_clk;

    xosc_fail_monitor dut_i (
        .ref_clk        (ref_clk),
        .rst_n          (rst_n),
        .mon_en         (mon_en),
        .xosc_on        (xosc_on),
        .xosc_ready     (xosc_ready),
        .xosc_clk       (xosc_clk),
        .sys_src        (sys_src),
        .pll_src_ext    (pll_src_ext),
        .irq_clr        (irq_clr),
        .fail_irq       (fail_irq),
        .brk_pulse      (brk_pulse),
        .xosc_force_off (xosc_force_off),
        .fallback_req   (fallback_req)
    );

    // external clock model, toggles on falling reference edges
    always @(negedge ref_clk) begin
        if (half_per != 0) begin
            if (ext_cnt + 1 >= half_per) begin
                xosc_clk <= ~xosc_clk;
                ext_cnt  <= 0;
            end else begin
                ext_cnt <= ext_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic stop_ext();
        half_per = 0;
        xosc_clk = 1'b0;
        tick(6);
    endtask

    task automatic recover();
        xosc_on    = 1'b0;
        xosc_ready = 1'b0;
        irq_clr    = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        tick(2);
    endtask

    initial begin
        repeat (100000) @(posedge ref_clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 irq", int'(fail_irq), 0);
        chk("R1 brk", int'(brk_pulse), 0);
        chk("R1 force", int'(xosc_force_off), 0);
        chk("R1 fallback", int'(fallback_req), 0);
        rst_n = 1'b1;
        tick(2);

        // table walk, R5
        mon_en  = 1'b1;
        sys_src = 2'b00;
        for (int v = 0; v < NVEC; v++) begin
            recover();
            half_per = HALF_TAB[v];
            xosc_clk = 1'b0;
            ext_cnt  = 0;
            tick(12);
            xosc_on    = 1'b1;
            xosc_ready = 1'b1;
            tick(80);
            chk($sformatf("R5 rate half=%0d", HALF_TAB[v]), int'(fail_irq), int'(FAIL_TAB[v]));
        end
        recover();
        stop_ext();

        // R2 enable low
        mon_en = 1'b0; xosc_on = 1'b1; xosc_ready = 1'b1;
        tick(60);
        chk("R2 disabled irq", int'(fail_irq), 0);
        chk("R2 disabled force", int'(xosc_force_off), 0);
        xosc_on = 1'b0; xosc_ready = 1'b0; mon_en = 1'b1;
        tick(2);

        // R3 on but not ready
        xosc_on = 1'b1;
        tick(60);
        chk("R3 not ready", int'(fail_irq), 0);
        xosc_on = 1'b0;
        tick(2);

        // R4 drop on mid-window
        xosc_on = 1'b1; xosc_ready = 1'b1;
        tick(10);
        xosc_on = 1'b0; xosc_ready = 1'b0;
        tick(40);
        chk("R4 disarm irq", int'(fail_irq), 0);
        chk("R4 disarm brk", int'(brk_pulse), 0);

        // R6 exact timing, R7, R8, R10 external direct
        sys_src = 2'b01;
        xosc_on = 1'b1; xosc_ready = 1'b1;
        tick(16);
        chk("R6 not after 15", int'(fail_irq), 0);
        tick(1);
        chk("R6 irq after 16", int'(fail_irq), 1);
        chk("R8 brk high", int'(brk_pulse), 1);
        chk("R7 force rises", int'(xosc_force_off), 1);
        chk("R10 ext fallback", int'(fallback_req), 1);
        tick(1);
        chk("R8 brk one cycle", int'(brk_pulse), 0);
        chk("R7 force held", int'(xosc_force_off), 1);
        chk("R9 irq sticky", int'(fail_irq), 1);
        tick(5);
        chk("R7 force still held", int'(xosc_force_off), 1);
        xosc_on = 1'b0; xosc_ready = 1'b0;
        tick(1);
        chk("R7 force released", int'(xosc_force_off), 0);
        chk("R9 irq before clear", int'(fail_irq), 1);
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        chk("R9 irq cleared", int'(fail_irq), 0);
        chk("R10 fallback cleared", int'(fallback_req), 0);

        // R9 set wins, R10 PLL from external
        sys_src = 2'b10; pll_src_ext = 1'b1;
        xosc_on = 1'b1; xosc_ready = 1'b1;
        tick(16);
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        chk("R9 set wins over clear", int'(fail_irq), 1);
        chk("R10 pll ext fallback", int'(fallback_req), 1);
        recover();

        // R10 PLL from internal source
        pll_src_ext = 1'b0;
        xosc_on = 1'b1; xosc_ready = 1'b1;
        tick(17);
        chk("R10 pll int irq", int'(fail_irq), 1);
        chk("R10 pll int no fallback", int'(fallback_req), 0);
        recover();

        // R10 internal RC source
        sys_src = 2'b00;
        xosc_on = 1'b1; xosc_ready = 1'b1;
        tick(17);
        chk("R10 rc irq", int'(fail_irq), 1);
        chk("R10 rc no fallback", int'(fallback_req), 0);
        recover();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule